// File: doc/BRIEF.md
# Prefix Width Decoder

This block sits in front of the instruction decoder of an accumulator CPU with an 8-bit data bus. It watches each opcode byte at its fetch strobe. A byte whose low nibble is F and whose upper nibble is not zero is a width prefix. The upper nibble of the prefix picks the register width and the address width for the next instruction only. There is no mode flag. After that instruction finishes, or when an unprefixed opcode is fetched, the widths go back to 8-bit registers and 16-bit addresses.

The opcode with upper nibble zero and low nibble F is not a prefix. It is a capability query. The block raises a one-cycle strobe, and the execution unit copies a fixed descriptor byte into the accumulator. The descriptor uses the same nibble layout as the prefix. Its low nibble is a thread count, which is zero here.

The block signals "prefix consumed" in the same cycle as the fetch, so the main decoder can discard the byte and fetch the real opcode on the next strobe. A prefix therefore never counts as an instruction of its own.

Top module: `pfx_width_decoder`

## Requirements
- R1: While reset is active, and right after it, regWidth and addrWidth read 00 and capHit reads 0.
- R2: prefixTaken is high in the same cycle exactly when syncStrobe is high, opByte[3:0] is F and opByte[7:4] is nonzero. The query byte 0x0F does not raise it. A byte with low nibble F that arrives without syncStrobe does not raise it and leaves the widths unchanged.
- R3: One cycle after a prefix fetch, regWidth equals opByte[7:6] and addrWidth equals opByte[5:4]. The register codes are 00 for 8 bits, 01 for 16 bits and 10 for 24 bits. The address codes are 00 for 16 bits and 01 for 24 bits.
- R4: The prefixed widths hold through the next opcode fetch until instrDone of that instruction. They also hold until a later fetch of a non-prefix opcode, whichever comes first. They return to 00/00 one cycle after that event.
- R5: An instrDone between a prefix fetch and the next opcode fetch is ignored.
- R6: When several prefixes are fetched in a row, the last one sets the widths.
- R7: An opcode fetched with no prefix in front runs with regWidth 00 and addrWidth 00.
- R8: A fetch of 0x0F raises capHit for exactly the following cycle. This applies with or without a prefix in front.
- R9: The reserved register code 11 maps to 10 (24 bits). The address codes 10 and 11 map to 01 (24 bits).
- R10: If a prefix fetch and instrDone fall in the same cycle, the prefix is loaded.
- R11: capByte is the constant {REG_CAP[1:0], ADDR_CAP[1:0], THREAD_CNT[3:0]}. With the default parameters this is 0x90.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| opByte | input | 8 | Byte on the data-in bus |
| syncStrobe | input | 1 | High in an opcode fetch cycle |
| instrDone | input | 1 | High in the last cycle of an instruction |
| regWidth | output | 2 | Register width code for the current instruction |
| addrWidth | output | 2 | Address width code for the current instruction |
| prefixTaken | output | 1 | The byte being fetched is a prefix; do not execute it |
| capHit | output | 1 | Load capByte into the accumulator this cycle |
| capByte | output | 8 | Capability descriptor |

## Verification
The bench uses the default parameters: 24-bit registers, 24-bit addresses and no threads. With these, capByte reads 0x90, and every prefix code, including the reserved ones, reaches the width outputs without any limit from the part's capability. The stimulus covers all the ways a prefix can end:
- a done strobe after the bound opcode,
- a second prefix,
- an unprefixed fetch while the widths are still bound,
- a done that coincides with a new prefix.

It also covers a done strobe that lands before the bound opcode has been fetched.

// File: rtl/pfx_pkg.sv
package pfx_pkg;

  typedef logic [1:0] widthCode_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_BOUND = 2'd2
  } pfxState_t;

  typedef struct packed {
    logic loadPrefix;
    logic clearWidths;
    logic queryHit;
  } ctrlStrobe_t;

  // reserved register code 11 runs as 24-bit
  function automatic widthCode_t mapRegCode(input logic [1:0] raw);
    return (raw == 2'b11) ? 2'b10 : raw;
  endfunction

  // any address code with bit 1 set runs as 24-bit
  function automatic widthCode_t mapAddrCode(input logic [1:0] raw);
    return raw[1] ? 2'b01 : raw;
  endfunction

endpackage

// File: rtl/pfx_ctrl.sv
module pfx_ctrl
  import pfx_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        syncStrobe,
  input  logic        instrDone,
  input  logic        isPrefixForm,
  input  logic        isQueryOp,
  output ctrlStrobe_t strobes,
  output logic        prefixTaken
);

  pfxState_t state, stateNext;

  always_comb begin
    stateNext           = state;
    strobes.loadPrefix  = 1'b0;
    strobes.clearWidths = 1'b0;
    strobes.queryHit    = syncStrobe && isQueryOp;
    prefixTaken         = syncStrobe && isPrefixForm;

    if (syncStrobe && isPrefixForm) begin
      strobes.loadPrefix = 1'b1;
      stateNext          = ST_ARMED;
    end else begin
      unique case (state)
        ST_ARMED: if (syncStrobe) stateNext = ST_BOUND;
        ST_BOUND: if (instrDone || syncStrobe) begin
          strobes.clearWidths = 1'b1;
          stateNext           = ST_IDLE;
        end
        default: stateNext = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

endmodule

// File: rtl/pfx_datapath.sv
module pfx_datapath
  import pfx_pkg::*;
#(
  parameter int OP_W       = 8,
  parameter int REG_CAP    = 2,
  parameter int ADDR_CAP   = 1,
  parameter int THREAD_CNT = 0
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [OP_W-1:0] opByte,
  input  ctrlStrobe_t     strobes,
  output logic            isPrefixForm,
  output logic            isQueryOp,
  output widthCode_t      regWidth,
  output widthCode_t      addrWidth,
  output logic            capHit,
  output logic [OP_W-1:0] capByte
);

  localparam int NIB_W = OP_W / 2;
  localparam logic [NIB_W-1:0] PFX_TAG = '1;
  localparam logic [OP_W-1:0] CAP_DESC =
    {REG_CAP[1:0], ADDR_CAP[1:0], THREAD_CNT[NIB_W-1:0]};

  logic [NIB_W-1:0] hiNib, loNib;

  assign hiNib        = opByte[OP_W-1:NIB_W];
  assign loNib        = opByte[NIB_W-1:0];
  assign isPrefixForm = (loNib == PFX_TAG) && (hiNib != '0);
  assign isQueryOp    = (loNib == PFX_TAG) && (hiNib == '0);
  assign capByte      = CAP_DESC;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      regWidth  <= 2'b00;
      addrWidth <= 2'b00;
      capHit    <= 1'b0;
    end else begin
      capHit <= strobes.queryHit;
      if (strobes.loadPrefix) begin
        regWidth  <= mapRegCode(hiNib[NIB_W-1 -: 2]);
        addrWidth <= mapAddrCode(hiNib[NIB_W-3 -: 2]);
      end else if (strobes.clearWidths) begin
        regWidth  <= 2'b00;
        addrWidth <= 2'b00;
      end
    end
  end

endmodule

// File: rtl/pfx_width_decoder.sv
module pfx_width_decoder
  import pfx_pkg::*;
#(
  parameter int OP_W       = 8,
  parameter int REG_CAP    = 2,
  parameter int ADDR_CAP   = 1,
  parameter int THREAD_CNT = 0
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [OP_W-1:0] opByte,
  input  logic            syncStrobe,
  input  logic            instrDone,
  output logic [1:0]      regWidth,
  output logic [1:0]      addrWidth,
  output logic            prefixTaken,
  output logic            capHit,
  output logic [OP_W-1:0] capByte
);

  ctrlStrobe_t strobes;
  logic        isPrefixForm, isQueryOp;

  pfx_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .syncStrobe   (syncStrobe),
    .instrDone    (instrDone),
    .isPrefixForm (isPrefixForm),
    .isQueryOp    (isQueryOp),
    .strobes      (strobes),
    .prefixTaken  (prefixTaken)
  );

  pfx_datapath #(
    .OP_W       (OP_W),
    .REG_CAP    (REG_CAP),
    .ADDR_CAP   (ADDR_CAP),
    .THREAD_CNT (THREAD_CNT)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .opByte       (opByte),
    .strobes      (strobes),
    .isPrefixForm (isPrefixForm),
    .isQueryOp    (isQueryOp),
    .regWidth     (regWidth),
    .addrWidth    (addrWidth),
    .capHit       (capHit),
    .capByte      (capByte)
  );

endmodule

// File: rtl/pfx_checker.sv
module pfx_checker #(
  parameter int OP_W = 8
) (
  input logic            clk,
  input logic            rstN,
  input logic [OP_W-1:0] opByte,
  input logic            syncStrobe,
  input logic            instrDone,
  input logic [1:0]      regWidth,
  input logic [1:0]      addrWidth,
  input logic            prefixTaken,
  input logic            capHit
);

  AST_RESET_WIDTHS: assert property (@(posedge clk)
    !rstN |=> (regWidth == 2'b00) && (addrWidth == 2'b00) && !capHit); // R1

  AST_FLAG_NEEDS_SYNC: assert property (@(posedge clk) disable iff (!rstN)
    prefixTaken |-> syncStrobe); // R2

  AST_PREFIX_REG_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    prefixTaken |=> regWidth == (($past(opByte[7:6]) == 2'b11) ? 2'b10 : $past(opByte[7:6]))); // R3

  AST_PREFIX_ADDR_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    prefixTaken |=> addrWidth == ($past(opByte[5]) ? 2'b01 : $past(opByte[5:4]))); // R3

  AST_REG_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    regWidth != 2'b11); // R9

  AST_ADDR_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    !addrWidth[1]); // R9

  AST_WIDTHS_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!syncStrobe && !instrDone) |=> $stable(regWidth) && $stable(addrWidth)); // R4

  AST_QUERY_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    (syncStrobe && opByte == 8'h0F) |=> capHit); // R8

  AST_QUERY_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    capHit |-> $past(syncStrobe && opByte == 8'h0F)); // R8

endmodule

bind pfx_width_decoder pfx_checker #(.OP_W(OP_W)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .opByte      (opByte),
  .syncStrobe  (syncStrobe),
  .instrDone   (instrDone),
  .regWidth    (regWidth),
  .addrWidth   (addrWidth),
  .prefixTaken (prefixTaken),
  .capHit      (capHit)
);

// File: tb/sim_pfx_width_decoder.sv
`timescale 1ns/1ps
module sim_pfx_width_decoder;

  typedef struct {
    logic [1:0] eReg;
    logic [1:0] eAddr;
    logic       ePfx;
    logic       eCap;
    string      tag;
  } expItem_t;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] opByte = 8'h00;
  logic       syncStrobe = 1'b0;
  logic       instrDone = 1'b0;
  logic [1:0] regWidth, addrWidth;
  logic       prefixTaken, capHit;
  logic [7:0] capByte;

  int checks = 0;
  int fails = 0;
  bit stopMon = 1'b0;
  expItem_t expQ[$];

  always #4 clk = ~clk;

  pfx_width_decoder u0 (
    .clk(clk), .rstN(rstN), .opByte(opByte), .syncStrobe(syncStrobe),
    .instrDone(instrDone), .regWidth(regWidth), .addrWidth(addrWidth),
    .prefixTaken(prefixTaken), .capHit(capHit), .capByte(capByte)
  );

  // expected values apply to the cycle in which the inputs are driven
  task automatic step(input logic [7:0] op, input logic s, input logic d,
                      input logic [1:0] eR, input logic [1:0] eA,
                      input logic eP, input logic eC, input string tag);
    expItem_t it;
    @(negedge clk);
    opByte = op; syncStrobe = s; instrDone = d;
    it.eReg = eR; it.eAddr = eA; it.ePfx = eP; it.eCap = eC; it.tag = tag;
    expQ.push_back(it);
  endtask

  // monitor: pops one item per cycle, mid-way between edges
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (stopMon) break;
      if (expQ.size() > 0) begin
        expItem_t it;
        it = expQ.pop_front();
        checks++;
        if (regWidth !== it.eReg || addrWidth !== it.eAddr ||
            prefixTaken !== it.ePfx || capHit !== it.eCap) begin
          fails++;
          $display("FAIL %s: got reg=%b addr=%b pfx=%b cap=%b, expected reg=%b addr=%b pfx=%b cap=%b",
                   it.tag, regWidth, addrWidth, prefixTaken, capHit,
                   it.eReg, it.eAddr, it.ePfx, it.eCap);
        end
      end
    end
  end

  initial begin
    #(200000 * 8);
    fails++;
    checks++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #2;
    checks++;
    if (regWidth !== 2'b00 || addrWidth !== 2'b00 || capHit !== 1'b0) begin
      fails++;
      $display("FAIL R1: got reg=%b addr=%b cap=%b, expected 00 00 0", regWidth, addrWidth, capHit);
    end
    @(negedge clk);
    rstN = 1'b1;

    step(8'h00, 0, 0, 2'd0, 2'd0, 0, 0, "R1");
    step(8'hEA, 1, 0, 2'd0, 2'd0, 0, 0, "R7");
    step(8'h00, 0, 1, 2'd0, 2'd0, 0, 0, "R7");
    step(8'h4F, 1, 0, 2'd0, 2'd0, 1, 0, "R2");
    step(8'hA9, 1, 0, 2'd1, 2'd0, 0, 0, "R3");
    step(8'h34, 0, 0, 2'd1, 2'd0, 0, 0, "R4");
    step(8'h12, 0, 1, 2'd1, 2'd0, 0, 0, "R4");
    step(8'hEA, 1, 0, 2'd0, 2'd0, 0, 0, "R4");
    step(8'h00, 0, 1, 2'd0, 2'd0, 0, 0, "R7");
    step(8'h9F, 1, 0, 2'd0, 2'd0, 1, 0, "R2");
    step(8'h00, 0, 1, 2'd2, 2'd1, 0, 0, "R5");
    step(8'hAD, 1, 0, 2'd2, 2'd1, 0, 0, "R5");
    step(8'h00, 0, 0, 2'd2, 2'd1, 0, 0, "R4");
    step(8'h00, 0, 1, 2'd2, 2'd1, 0, 0, "R4");
    step(8'h1F, 1, 0, 2'd0, 2'd0, 1, 0, "R2");
    step(8'h8F, 1, 0, 2'd0, 2'd1, 1, 0, "R6");
    step(8'hA5, 1, 0, 2'd2, 2'd0, 0, 0, "R6");
    step(8'h00, 0, 1, 2'd2, 2'd0, 0, 0, "R4");
    step(8'hCF, 1, 0, 2'd0, 2'd0, 1, 0, "R9");
    step(8'hB5, 1, 0, 2'd2, 2'd0, 0, 0, "R9");
    step(8'h00, 0, 1, 2'd2, 2'd0, 0, 0, "R4");
    step(8'h3F, 1, 0, 2'd0, 2'd0, 1, 0, "R9");
    step(8'hEA, 1, 0, 2'd0, 2'd1, 0, 0, "R9");
    step(8'h0F, 1, 0, 2'd0, 2'd1, 0, 0, "R2");
    step(8'h00, 0, 1, 2'd0, 2'd0, 0, 1, "R8");
    step(8'h00, 0, 0, 2'd0, 2'd0, 0, 0, "R8");
    step(8'h4F, 1, 1, 2'd0, 2'd0, 1, 0, "R10");
    step(8'hEA, 1, 0, 2'd1, 2'd0, 0, 0, "R10");
    step(8'h00, 0, 1, 2'd1, 2'd0, 0, 0, "R4");
    step(8'h4F, 0, 0, 2'd0, 2'd0, 0, 0, "R2");
    step(8'hEA, 1, 0, 2'd0, 2'd0, 0, 0, "R2");
    step(8'h9F, 1, 0, 2'd0, 2'd0, 1, 0, "R2");
    step(8'h0F, 1, 0, 2'd2, 2'd1, 0, 0, "R8");
    step(8'h00, 0, 1, 2'd2, 2'd1, 0, 1, "R8");
    step(8'h00, 0, 0, 2'd0, 2'd0, 0, 0, "R4");

    @(negedge clk);
    #3;
    checks++;
    if (capByte !== 8'h90) begin
      fails++;
      $display("FAIL R11: got capByte=%h, expected 90", capByte);
    end
    repeat (2) @(negedge clk);
    stopMon = 1'b1;
    if (expQ.size() != 0) begin
      fails++;
      checks++;
      $display("FAIL scoreboard: got %0d unchecked items, expected 0", expQ.size());
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule